// File: doc/BRIEF.md
# Run-Length Bit-Stream Expander

This block turns a stream of compressed code bytes into a serial bit stream for loading a configuration image. Code bytes arrive over a valid/ready byte interface. The expanded bits leave over a valid/ready interface, one bit per transfer. After reset, and before any decoded bit, the block sends a fixed synchronisation word. Only then does it start accepting code bytes.

Each code byte stands for a short run of bits. A parameter, `MAX_ONES`, sets where the code ranges split. The small codes mean "this many ones, then a zero". The code just above the threshold means "a full run of ones with no closing zero". The codes above that mean "a run of zeros, then a single one". The all-ones code means a lone one. Code zero carries no bits. The block takes a new byte only once every bit of the previous byte has been handed off.

Top module: `rld_top`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` is 1 and `in_ready` is 0.
- R2: The first bits sent after reset are the `SYNC_W`-bit word `SYNC_PAT`, most significant bit first (default 16 bits, 0xFF20). `in_ready` stays 0 until every bit of the word has been handed off.
- R3: A code n with 1 <= n <= `MAX_ONES` expands to n ones followed by one zero.
- R4: The code `MAX_ONES`+1 expands to exactly `MAX_ONES` ones, with no zero after them.
- R5: A code n with `MAX_ONES`+2 <= n <= 254 expands to n-(`MAX_ONES`+2) zeros followed by one one. This means code `MAX_ONES`+2 gives a single one.
- R6: The code 255 (all code bits set) expands to a single one.
- R7: The code 0 is accepted and produces no output bit. In the cycle after it is accepted, `in_ready` is 1 and `out_valid` is 0.
- R8: `in_ready` is 0 whenever a bit of the current code is still waiting to be handed off. It is 0 in the cycle after any non-zero code is accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_bit` unchanged. No bit is lost or repeated when the sink stalls.
- R10: When no code is pending and `in_valid` is 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Code byte on `in_code` is valid |
| in_ready | output | 1 | Block can take a code byte this cycle |
| in_code | input | CODE_W | Compressed code byte |
| out_valid | output | 1 | `out_bit` holds a bit to hand off |
| out_ready | input | 1 | Sink takes the bit this cycle |
| out_bit | output | 1 | Expanded serial bit |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a threshold of 226 and the 16-bit word 0xFF20. These values bring every code range into reach within a short run. The longest one-run (226 bits, code 227) and the longest zero-run (26 zeros from code 254) both fit inside a few hundred cycles. The edges of every range are tested: 1, 226, 227, 228, 229, 254, 255 and 0. A mixed sequence of back-to-back codes is also run against a sink that stalls on one cycle in three.

// File: rtl/rld_pkg.sv
package rld_pkg;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_IDLE = 2'd1,
        PH_LEAD = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    // Shape of one expanded run: a repeated lead bit, then an optional single tail bit.
    typedef struct packed {
        logic lead_bit;
        logic tail_en;
        logic tail_bit;
    } run_shape_t;

endpackage

// File: rtl/rld_classify.sv
module rld_classify
    import rld_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int MAX_ONES = 226,
    parameter int CNT_W    = 8
) (
    input  logic [CODE_W-1:0] code,
    output run_shape_t        shape,
    output logic [CNT_W-1:0]  lead_len,
    output logic              is_empty
);
    localparam int ALL_CODE  = (1 << CODE_W) - 1;
    localparam int ZERO_BASE = MAX_ONES + 2;

    logic [31:0] code_u;
    assign code_u = 32'(code);

    always_comb begin
        shape    = '0;
        lead_len = '0;
        is_empty = 1'b0;
        if (code_u == 32'd0) begin
            is_empty = 1'b1;
        end else if (code_u <= 32'(MAX_ONES)) begin
            shape.lead_bit = 1'b1;
            shape.tail_en  = 1'b1;
            shape.tail_bit = 1'b0;
            lead_len       = CNT_W'(code_u);
        end else if (code_u == 32'(MAX_ONES + 1)) begin
            shape.lead_bit = 1'b1;
            shape.tail_en  = 1'b0;
            lead_len       = CNT_W'(MAX_ONES);
        end else if (code_u == 32'(ALL_CODE)) begin
            shape.lead_bit = 1'b0;
            shape.tail_en  = 1'b1;
            shape.tail_bit = 1'b1;
            lead_len       = '0;
        end else begin
            shape.lead_bit = 1'b0;
            shape.tail_en  = 1'b1;
            shape.tail_bit = 1'b1;
            lead_len       = CNT_W'(code_u - 32'(ZERO_BASE));
        end
    end

endmodule

// File: rtl/rld_emitter.sv
module rld_emitter
    import rld_pkg::*;
#(
    parameter int              CNT_W    = 8,
    parameter int              SYNC_W   = 16,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 16'hFF20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  run_shape_t       dec_shape,
    input  logic [CNT_W-1:0] dec_len,
    input  logic             dec_empty,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit
);
    localparam int SIDX_W = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;
    localparam logic [SIDX_W-1:0] SIDX_LAST = SIDX_W'(SYNC_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [SIDX_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
        run_shape_t        shape;
    } emit_st_t;

    emit_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_SYNC: begin
                if (out_ready) begin
                    if (st_q.idx == SIDX_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            PH_IDLE: begin
                if (in_valid && !dec_empty) begin
                    st_d.shape = dec_shape;
                    st_d.cnt   = dec_len;
                    st_d.phase = (dec_len != '0) ? PH_LEAD : PH_TAIL;
                end
            end
            PH_LEAD: begin
                if (out_ready) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.phase = st_q.shape.tail_en ? PH_TAIL : PH_IDLE;
                    end
                end
            end
            PH_TAIL: begin
                if (out_ready) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_SYNC;
            st_q.idx   <= '0;
            st_q.cnt   <= '0;
            st_q.shape <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_ready  = (st_q.phase == PH_IDLE);
        out_valid = (st_q.phase != PH_IDLE);
        unique case (st_q.phase)
            PH_SYNC: out_bit = SYNC_PAT[SIDX_LAST - st_q.idx];
            PH_LEAD: out_bit = st_q.shape.lead_bit;
            PH_TAIL: out_bit = st_q.shape.tail_bit;
            default: out_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rld_top.sv
module rld_top
    import rld_pkg::*;
#(
    parameter int                CODE_W   = 8,
    parameter int                MAX_ONES = 226,
    parameter int                SYNC_W   = 16,
    parameter logic [SYNC_W-1:0] SYNC_PAT = 16'hFF20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_bit
);
    localparam int CNT_W = $clog2(MAX_ONES + 1);

    run_shape_t       dec_shape;
    logic [CNT_W-1:0] dec_len;
    logic             dec_empty;

    rld_classify #(
        .CODE_W  (CODE_W),
        .MAX_ONES(MAX_ONES),
        .CNT_W   (CNT_W)
    ) u_classify (
        .code    (in_code),
        .shape   (dec_shape),
        .lead_len(dec_len),
        .is_empty(dec_empty)
    );

    rld_emitter #(
        .CNT_W   (CNT_W),
        .SYNC_W  (SYNC_W),
        .SYNC_PAT(SYNC_PAT)
    ) u_emitter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .dec_shape(dec_shape),
        .dec_len  (dec_len),
        .dec_empty(dec_empty),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_bit  (out_bit)
    );

endmodule

// File: rtl/rld_checker.sv
module rld_checker #(
    parameter int CODE_W   = 8,
    parameter int MAX_ONES = 226,
    parameter int SYNC_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [CODE_W-1:0] in_code,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_bit
);
    localparam int SC_W = $clog2(SYNC_W + 1);
    localparam logic [CODE_W-1:0] ALL_CODE = '1;

    logic [SC_W-1:0] sync_seen_q;
    logic            accept;

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_seen_q <= '0;
        end else if (out_valid && out_ready && (sync_seen_q < SC_W'(SYNC_W))) begin
            sync_seen_q <= sync_seen_q + 1'b1;
        end
    end

    // R2
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_seen_q < SC_W'(SYNC_W)) |-> !in_ready);

    // R3
    ones_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_code != '0 && 32'(in_code) <= 32'(MAX_ONES)) |=> (out_valid && out_bit));

    // R4
    bare_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && 32'(in_code) == 32'(MAX_ONES + 1)) |=> (out_valid && out_bit));

    // R5
    zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && 32'(in_code) == 32'(MAX_ONES + 2)) |=> (out_valid && out_bit));

    // R6
    lone_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_code == ALL_CODE) |=> (out_valid && out_bit));

    // R7
    empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_code == '0) |=> (in_ready && !out_valid));

    // R8
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_code != '0) |=> !in_ready);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

endmodule

bind rld_top rld_checker #(
    .CODE_W  (CODE_W),
    .MAX_ONES(MAX_ONES),
    .SYNC_W  (SYNC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_code  (in_code),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_bit  (out_bit)
);

// File: tb/tb_rld_top.sv
module tb_rld_top;
    localparam int MAXO = 226;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_code = 8'd0;
    logic       out_ready = 1'b1;
    logic       in_ready, out_valid, out_bit;

    int checks = 0;
    int fails = 0;
    int ready_mode = 0;
    int cyc = 0;
    int stall_err = 0;
    int overlap_err = 0;
    logic prev_stall = 1'b0;
    logic prev_bit = 1'b0;
    logic got[$];
    logic exp_q[$];

    always #5 clk = ~clk;

    rld_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
    );

    // Sink driver and bit monitor: ready set at the falling edge, handshake sampled 1 ns later.
    always @(negedge clk) begin
        cyc++;
        out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        #1;
        if (rst_n) begin
            if (prev_stall && (!out_valid || out_bit !== prev_bit)) stall_err++;
            if (out_valid && in_ready) overlap_err++;
            if (out_valid && out_ready) got.push_back(out_bit);
            prev_stall = out_valid && !out_ready;
            prev_bit   = out_bit;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic add_code(input int c);
        if (c == 0) begin
        end else if (c <= MAXO) begin
            for (int i = 0; i < c; i++) exp_q.push_back(1'b1);
            exp_q.push_back(1'b0);
        end else if (c == MAXO + 1) begin
            for (int i = 0; i < MAXO; i++) exp_q.push_back(1'b1);
        end else if (c == 255) begin
            exp_q.push_back(1'b1);
        end else begin
            for (int i = 0; i < c - (MAXO + 2); i++) exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
        end
    endtask

    task automatic cmp_stream(input string req);
        int bad = -1;
        chk(got.size() == exp_q.size(), {req, " length"}, got.size(), exp_q.size());
        if (got.size() == exp_q.size()) begin
            for (int i = 0; i < got.size(); i++)
                if (bad < 0 && got[i] !== exp_q[i]) bad = i;
        end
        chk(bad < 0, {req, " first bad bit index"}, bad, -1);
    endtask

    // Called just after a falling edge; returns just after the falling edge that follows acceptance.
    task automatic send_code(input int c);
        bit done = 0;
        in_valid = 1'b1;
        in_code  = 8'(c);
        while (!done) begin
            #2;
            if (in_ready) done = 1;
            @(negedge clk);
        end
    endtask

    task automatic drain();
        int idle = 0;
        int n = 0;
        while (idle < 2 && n < 2000) begin
            @(negedge clk);
            #2;
            n++;
            if (in_ready && !out_valid) idle++;
            else idle = 0;
        end
    endtask

    task automatic t_reset_sync();
        rst_n = 1'b0;
        in_valid = 1'b0;
        ready_mode = 0;
        #2;
        // R1 during reset
        chk(out_valid == 1'b1, "R1 out_valid in reset", out_valid, 1);
        chk(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
        repeat (3) @(negedge clk);
        got.delete();
        exp_q.delete();
        rst_n = 1'b1;
        #2;
        chk(out_valid == 1'b1 && in_ready == 1'b0, "R1 after release", {out_valid, in_ready}, 2);
        repeat (8) @(negedge clk);
        #2;
        chk(in_ready == 1'b0, "R2 in_ready mid sync", in_ready, 0);
        drain();
        for (int i = 15; i >= 0; i--) exp_q.push_back(16'hFF20 >> i);
        cmp_stream("R2 sync word");
    endtask

    task automatic t_single(input int c, input string req);
        @(negedge clk);
        got.delete();
        exp_q.delete();
        add_code(c);
        send_code(c);
        in_valid = 1'b0;
        drain();
        cmp_stream(req);
    endtask

    task automatic t_busy();
        @(negedge clk);
        got.delete();
        exp_q.delete();
        add_code(50);
        send_code(50);
        in_valid = 1'b1;
        in_code  = 8'd3;
        repeat (4) @(negedge clk);
        #2;
        // R8: a waiting byte is not taken while the run is still going out
        chk(in_ready == 1'b0 && out_valid == 1'b1, "R8 busy mid run", {in_ready, out_valid}, 1);
        in_valid = 1'b0;
        drain();
        cmp_stream("R8 run not disturbed");
    endtask

    task automatic t_idle();
        drain();
        repeat (3) @(negedge clk);
        #2;
        chk(out_valid == 1'b0, "R10 out_valid idle", out_valid, 0);
        chk(in_ready == 1'b1, "R10 in_ready idle", in_ready, 1);
    endtask

    task automatic t_stream();
        int seq[8] = '{3, 0, 230, 227, 255, 226, 1, 240};
        @(negedge clk);
        ready_mode = 1;
        got.delete();
        exp_q.delete();
        stall_err = 0;
        overlap_err = 0;
        foreach (seq[i]) add_code(seq[i]);
        foreach (seq[i]) send_code(seq[i]);
        in_valid = 1'b0;
        drain();
        cmp_stream("R9 stalled stream");
        chk(stall_err == 0, "R9 hold under stall", stall_err, 0);
        chk(overlap_err == 0, "R8 ready while bits pending", overlap_err, 0);
        ready_mode = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_sync();
        t_single(1,   "R3 code 1");
        t_single(226, "R3 code 226");
        t_single(227, "R4 code 227");
        t_single(228, "R5 code 228");
        t_single(229, "R5 code 229");
        t_single(254, "R5 code 254");
        t_single(255, "R6 code 255");
        t_single(0,   "R7 code 0");
        t_idle();
        t_busy();
        t_stream();
        t_idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule